// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block is the software-visible register file of a two-channel bus-master disk DMA controller. It decodes a 16-byte I/O window. Each channel owns an 8-byte slice: the lower slice serves channel 0 and the upper slice serves channel 1. A slice holds three things:

- a command byte;
- a status byte;
- a 32-bit pointer to the descriptor table that the DMA engine walks.

Software reaches the registers through a simple access port. Each access carries a valid strobe, a write flag, an address, a size code and write data. The block returns read data one cycle after the request.

The command byte and the pointer of every channel are driven out to the DMA engine. A one-cycle pulse marks each command write, so the engine can react to the start/stop bit (bit 0) and the direction bit (bit 3).

The engine drives back per-channel inputs that control three status flags. It can set the active flag (status bit 0) and also clear it. It can set the error flag (bit 1) and the interrupt flag (bit 2).

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, every command, status and pointer register of both channels is zero. `cmd_out`, `ptr_out` and `cmd_wr_pulse` are zero, and `rd_valid` is low.
- R2: Address bit 3 selects the channel: 0 for channel 0 and 1 for channel 1. Address bits 2:0 give the local offset. An access to one channel never changes the other channel.
- R3: A read request (`acc_valid` high, `acc_write` low) raises `rd_valid` for exactly the next cycle, with the result in `rd_data`. A byte read (`acc_size` = 0) at offset 0 returns the command byte, and at offset 2 returns the status byte. In both cases the value is in `rd_data[7:0]` and the upper bits are zero.
- R4: A byte read at offset 1 or 3 returns 0x000000FF. A write to offset 1 or 3 changes no register.
- R5: A status write copies written bits 6 and 5 into the status byte. Bits 7, 4 and 3 read back as zero afterwards, whatever was written.
- R6: A status write leaves status bit 0 (active) unchanged, whatever value is written to it.
- R7: In a status write, a 1 written to bit 1 or bit 2 clears that bit. A 0 written to either bit leaves it unchanged.
- R8: The hardware inputs take effect at the next clock edge and work as follows:
  - `hw_set_act`, `hw_set_err` and `hw_set_irq` set status bits 0, 1 and 2.
  - A set on bit 1 or bit 2 wins over a software clear of the same bit in the same cycle.
  - `hw_clr_act` clears bit 0, and `hw_set_act` wins over `hw_clr_act` when both are high.
- R9: Offsets 4 to 7 hold the pointer, whose byte lanes are numbered least significant first.
  - Sizes: `acc_size` 0 is a byte, 1 is a halfword (offset 4 or 6, data in bits 15:0) and 2 is a word (offset 4).
  - Writes: a write changes only the addressed lanes.
  - Reads: a read returns the addressed lanes right-aligned and zero-extended.
  - Low bits: pointer bits 1:0 are always zero.
- R10: A byte write at offset 0 stores the command byte. In the cycle after the write, `cmd_out` shows the new value and the channel's `cmd_wr_pulse` bit is high for one cycle. Without a write, `cmd_out` and `ptr_out` hold their values.
- R11: A halfword or word access at offsets 0 to 3 writes nothing and raises no command pulse. Such a read returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte address in the window |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_wdata | input | 32 | Write data, right-aligned |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | 32 | Read data |
| hw_set_act | input | 2 | Per channel: set status bit 0 |
| hw_clr_act | input | 2 | Per channel: clear status bit 0 |
| hw_set_err | input | 2 | Per channel: set status bit 1 |
| hw_set_irq | input | 2 | Per channel: set status bit 2 |
| cmd_out | output | 16 | Command bytes, channel 0 in bits 7:0 |
| ptr_out | output | 64 | Pointers, channel 0 in bits 31:0 |
| cmd_wr_pulse | output | 2 | Per channel: command was written |

## Verification
The assertions assume the following about the inputs:
- at most one access per cycle;
- `acc_size` is never 3;
- halfword accesses are halfword-aligned and word accesses use offset 4 of a slice;
- the access inputs are low while reset is held.

The stimulus drives every input on the falling clock edge from a single process and holds it for one full cycle. It returns `acc_valid` low between accesses and only issues aligned halfword and word accesses. As a result, every read result and command pulse the checker relates back to a request comes from exactly one well-formed access.

// File: rtl/bmdma_regfile.sv
module bmdma_regfile #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = CW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [NCH-1:0]    hw_set_act,
  input  logic [NCH-1:0]    hw_clr_act,
  input  logic [NCH-1:0]    hw_set_err,
  input  logic [NCH-1:0]    hw_set_irq,
  output logic [NCH*8-1:0]  cmd_out,
  output logic [NCH*32-1:0] ptr_out,
  output logic [NCH-1:0]    cmd_wr_pulse
);

  wire [2:0]    off     = acc_addr[2:0];
  wire [CW-1:0] chan    = acc_addr[AW-1:3];
  wire          is_byte = (acc_size == 2'd0);
  wire          is_half = (acc_size == 2'd1);
  wire          is_word = acc_size[1];

  wire [31:0] lane_data = is_byte ? {4{acc_wdata[7:0]}} :
                          is_half ? {2{acc_wdata[15:0]}} : acc_wdata;

  logic [3:0] lane_en;
  always_comb begin
    lane_en = 4'b0000;
    if (off[2]) begin
      if (is_byte)      lane_en = 4'b0001 << off[1:0];
      else if (is_half) lane_en = off[1] ? 4'b1100 : 4'b0011;
      else if (is_word) lane_en = 4'b1111;
    end
  end

  wire [31:0] lane_mask = {{8{lane_en[3]}}, {8{lane_en[2]}}, {8{lane_en[1]}}, {8{lane_en[0]}}};

  logic [31:0] rdat [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [7:0]  cmd_q;
    logic [7:0]  st_q;
    logic [31:0] ptr_q;
    logic [7:0]  st_sw;
    logic [7:0]  st_d;
    logic [31:0] ptr_rd;

    wire hit    = acc_valid && (chan == CW'(i));
    wire wr     = hit && acc_write;
    wire wr_cmd = wr && is_byte && (off == 3'd0);
    wire wr_st  = wr && is_byte && (off == 3'd2);
    wire wr_ptr = wr && (lane_en != 4'b0000);

    always_comb begin
      st_sw = st_q;
      if (wr_st)
        st_sw = {1'b0, acc_wdata[6:5], 2'b00, st_q[2:1] & ~acc_wdata[2:1], st_q[0]};
      st_d    = st_sw;
      st_d[2] = st_sw[2] | hw_set_irq[i];
      st_d[1] = st_sw[1] | hw_set_err[i];
      st_d[0] = hw_set_act[i] | (st_q[0] & ~hw_clr_act[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q           <= '0;
        st_q            <= '0;
        ptr_q           <= '0;
        cmd_wr_pulse[i] <= 1'b0;
      end else begin
        st_q            <= st_d;
        cmd_wr_pulse[i] <= wr_cmd;
        if (wr_cmd) cmd_q <= acc_wdata[7:0];
        if (wr_ptr) ptr_q <= ((ptr_q & ~lane_mask) | (lane_data & lane_mask)) & 32'hFFFF_FFFC;
      end
    end

    always_comb begin
      if (is_byte)      ptr_rd = (ptr_q >> {off[1:0], 3'b000}) & 32'h0000_00FF;
      else if (is_half) ptr_rd = off[1] ? {16'h0, ptr_q[31:16]} : {16'h0, ptr_q[15:0]};
      else              ptr_rd = ptr_q;
    end

    always_comb begin
      if (off[2])        rdat[i] = ptr_rd;
      else if (!is_byte) rdat[i] = 32'hFFFF_FFFF;
      else begin
        case (off[1:0])
          2'd0:    rdat[i] = {24'h0, cmd_q};
          2'd2:    rdat[i] = {24'h0, st_q};
          default: rdat[i] = 32'h0000_00FF;
        endcase
      end
    end

    assign cmd_out[i*8 +: 8]  = cmd_q;
    assign ptr_out[i*32 +: 32] = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= rdat[chan];
    end
  end

endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk #(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [AW-1:0]     acc_addr,
  input logic [1:0]        acc_size,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [NCH*8-1:0]  cmd_out,
  input logic [NCH*32-1:0] ptr_out,
  input logic [NCH-1:0]    cmd_wr_pulse
);

  p_rd_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  p_rd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);

  p_pad_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size == 2'd0 && acc_addr[0] && !acc_addr[2])
      |=> (rd_data == 32'h0000_00FF));

  p_cmd_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_pulse[0] |-> $past(acc_valid && acc_write && acc_size == 2'd0 && acc_addr == AW'(0)));

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(cmd_out));

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(ptr_out));

  p_wide_no_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size != 2'd0) |=> (cmd_wr_pulse == '0));

endmodule

bind bmdma_regfile bmdma_regfile_chk #(.NCH(NCH), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_size(acc_size), .rd_valid(rd_valid), .rd_data(rd_data),
  .cmd_out(cmd_out), .ptr_out(ptr_out), .cmd_wr_pulse(cmd_wr_pulse)
);

// File: tb/test_bmdma_regfile.sv
module test_bmdma_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  hw_set_act = '0, hw_clr_act = '0, hw_set_err = '0, hw_set_irq = '0;
  logic [15:0] cmd_out;
  logic [63:0] ptr_out;
  logic [1:0]  cmd_wr_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_regfile i_bmdma_regfile (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .hw_set_act(hw_set_act), .hw_clr_act(hw_clr_act),
    .hw_set_err(hw_set_err), .hw_set_irq(hw_set_irq),
    .cmd_out(cmd_out), .ptr_out(ptr_out), .cmd_wr_pulse(cmd_wr_pulse)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3: unexpected read result actual=%0h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), {32'h0, rd_data}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_valid in reset", {63'h0, rd_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cmd_out after reset", {48'h0, cmd_out}, 64'h0);
    check("R1 ptr_out after reset", ptr_out, 64'h0);
    check("R1 pulse after reset", {62'h0, cmd_wr_pulse}, 64'h0);
    rd(4'd0, 2'd0, 32'h0, "R1 ch0 cmd");
    rd(4'd2, 2'd0, 32'h0, "R1 ch0 status");
    rd(4'd4, 2'd2, 32'h0, "R1 ch0 ptr");
    rd(4'd10, 2'd0, 32'h0, "R1 ch1 status");

    wr(4'd0, 2'd0, 32'hFFFF_FF09);
    check("R10 pulse ch0", {62'h0, cmd_wr_pulse}, 64'h1);
    check("R10 cmd_out", {48'h0, cmd_out}, 64'h0009);
    @(negedge clk);
    check("R10 pulse one cycle", {62'h0, cmd_wr_pulse}, 64'h0);
    rd(4'd0, 2'd0, 32'h09, "R3 ch0 cmd");
    rd(4'd8, 2'd0, 32'h00, "R2 ch1 cmd untouched");
    wr(4'd8, 2'd0, 32'h08);
    check("R2 pulse ch1", {62'h0, cmd_wr_pulse}, 64'h2);
    rd(4'd8, 2'd0, 32'h08, "R2 ch1 cmd");
    rd(4'd0, 2'd0, 32'h09, "R2 ch0 cmd kept");

    rd(4'd1, 2'd0, 32'hFF, "R4 offset1");
    rd(4'd3, 2'd0, 32'hFF, "R4 offset3");
    rd(4'd11, 2'd0, 32'hFF, "R4 ch1 offset3");
    wr(4'd1, 2'd0, 32'hAA);
    wr(4'd3, 2'd0, 32'hFF);
    rd(4'd0, 2'd0, 32'h09, "R4 cmd after pad write");
    rd(4'd2, 2'd0, 32'h00, "R4 status after pad write");
    rd(4'd1, 2'd0, 32'hFF, "R4 offset1 after write");

    wr(4'd2, 2'd0, 32'hFF);
    rd(4'd2, 2'd0, 32'h60, "R5 R6 status write ff");

    hw_set_act = 2'b01; hw_set_err = 2'b01; hw_set_irq = 2'b01;
    @(negedge clk);
    hw_set_act = '0; hw_set_err = '0; hw_set_irq = '0;
    rd(4'd2, 2'd0, 32'h67, "R8 hw set all");
    rd(4'd10, 2'd0, 32'h00, "R2 ch1 status untouched");
    wr(4'd2, 2'd0, 32'h62);
    rd(4'd2, 2'd0, 32'h65, "R7 clear bit1 only");
    wr(4'd2, 2'd0, 32'h64);
    rd(4'd2, 2'd0, 32'h61, "R7 clear bit2");
    wr(4'd2, 2'd0, 32'h00);
    rd(4'd2, 2'd0, 32'h01, "R6 active kept on write 0");

    hw_set_err = 2'b01;
    wr(4'd2, 2'd0, 32'h02);
    hw_set_err = '0;
    rd(4'd2, 2'd0, 32'h03, "R8 set err beats clear");
    hw_set_irq = 2'b01;
    wr(4'd2, 2'd0, 32'h04);
    hw_set_irq = '0;
    rd(4'd2, 2'd0, 32'h07, "R8 set irq beats clear");
    wr(4'd2, 2'd0, 32'h06);
    rd(4'd2, 2'd0, 32'h01, "R7 clear both");
    hw_clr_act = 2'b01;
    @(negedge clk);
    hw_clr_act = '0;
    rd(4'd2, 2'd0, 32'h00, "R8 hw clear act");
    hw_set_act = 2'b01; hw_clr_act = 2'b01;
    @(negedge clk);
    hw_set_act = '0; hw_clr_act = '0;
    rd(4'd2, 2'd0, 32'h01, "R8 set beats clear act");

    wr(4'd4, 2'd2, 32'h1234_5677);
    rd(4'd4, 2'd2, 32'h1234_5674, "R9 word write low bits zero");
    wr(4'd6, 2'd0, 32'h0000_00AB);
    rd(4'd4, 2'd2, 32'h12AB_5674, "R9 byte lane 2");
    wr(4'd4, 2'd1, 32'h0000_CDEF);
    rd(4'd4, 2'd2, 32'h12AB_CDEC, "R9 half lanes 0-1");
    rd(4'd7, 2'd0, 32'h0000_0012, "R9 byte read 7");
    rd(4'd5, 2'd0, 32'h0000_00CD, "R9 byte read 5");
    rd(4'd6, 2'd1, 32'h0000_12AB, "R9 half read 6");
    check("R9 ptr_out", ptr_out, 64'h0000_0000_12AB_CDEC);
    wr(4'd4, 2'd0, 32'h0000_0003);
    rd(4'd4, 2'd2, 32'h12AB_CD00, "R9 byte 4 low bits zero");
    wr(4'd12, 2'd2, 32'hFFFF_FFFF);
    rd(4'd12, 2'd2, 32'hFFFF_FFFC, "R2 R9 ch1 ptr");
    check("R2 ptr_out both", ptr_out, 64'hFFFF_FFFC_12AB_CD00);

    wr(4'd0, 2'd1, 32'h0000_FFFF);
    check("R11 no pulse on half write", {62'h0, cmd_wr_pulse}, 64'h0);
    wr(4'd0, 2'd2, 32'hFFFF_FFFF);
    rd(4'd0, 2'd0, 32'h09, "R11 cmd unchanged");
    rd(4'd2, 2'd0, 32'h01, "R11 status unchanged");
    rd(4'd0, 2'd1, 32'hFFFF_FFFF, "R11 half read low");
    rd(4'd0, 2'd2, 32'hFFFF_FFFF, "R11 word read low");

    repeat (3) @(negedge clk);
    check("R3 all reads returned", {32'h0, 32'(exp_q.size())}, 64'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule